// File: doc/BRIEF.md
# Address-Range Instruction Prefetch Engine

The block turns one range-prefetch command into a short burst of cache-line fill requests toward an instruction cache. A command names a region of code. The region is given either as an inclusive lower byte address with an exclusive upper byte address, or as a start address with a byte count. The engine walks the region one 64-byte line at a time and offers each line address on a valid/ready request port. It stops after a bounded number of lines, or when the next line would start at or past the end of the region.

When it stops, the engine pulses a completion output that carries the first byte address it did not prefetch. Software writes that value back as the new lower bound and reissues the command until the returned address equals the end of the region. Each invocation therefore has a bounded latency, and a long region can be covered piece by piece from inside a loop.

Top module: `ifetch_range_pf`

## Requirements
- R1: The first line request of an invocation is the lower address rounded down to a multiple of 64. Each further request is 64 bytes above the previous one. No request is issued for a line whose base is at or above the end of the region, so the lower byte is covered and the end byte is not.
- R2: One invocation issues at most MAX_LINES line requests (default 4).
- R3: The completion address is the line boundary that follows the last accepted line, clamped so that it never exceeds the end of the region. Feeding it back as the new lower bound, with the end unchanged, continues the walk until the returned address equals the end.
- R4: If the lower address is greater than or equal to the end, no request is issued. The completion pulse appears one cycle after the command is accepted and returns the end address.
- R5: With cmd_form_i = 1 the end is cmd_lo_i + cmd_arg_i (a byte count), saturated at the all-ones address. With cmd_form_i = 0, cmd_arg_i is the exclusive end itself.
- R6: A line request counts as issued only in a cycle where req_valid_o and req_ready_i are both high. While req_ready_i is low, req_valid_o stays high and req_addr_o stays stable.
- R7: cmd_ready_o is high only while the engine is idle. A command held on the inputs while the engine is busy is not taken until the current invocation has completed, and it does not alter the requests or the result of that invocation.
- R8: done_valid_o is high for exactly one cycle per invocation. For a non-empty region it is high in the cycle after the last accepted line request.
- R9: Address arithmetic near the top of the address space does not wrap. A next-line address that would pass the end clamps to the end, including when the increment carries out of ADDR_W bits.
- R10: Every req_addr_o has its low 6 bits at zero.
- R11: During and after reset, cmd_ready_o is 1, req_valid_o is 0 and done_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle; command taken when both high |
| cmd_form_i | input | 1 | 0: arg is the exclusive end, 1: arg is a byte count |
| cmd_lo_i | input | ADDR_W | Inclusive lower byte address |
| cmd_arg_i | input | ADDR_W | Exclusive end address or byte count |
| req_valid_o | output | 1 | Line request offered |
| req_ready_i | input | 1 | Cache accepts the line request |
| req_addr_o | output | ADDR_W | 64-byte aligned line address |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_addr_o | output | ADDR_W | First byte address not prefetched |

## Verification
A command accepted at one clock edge makes the first line request visible right after that edge. Each request is retired at the edge where req_ready_i is high. The completion pulse is due exactly one cycle after the last retired request, or one cycle after acceptance when the region is empty. The bench predicts the line addresses and the completion address of each command when it queues that command. The monitor samples on the falling edge, pops a predicted line only on a cycle with a valid/ready handshake, and compares the pulse cycle against the cycle of the last handshake or of the acceptance. It runs both with a stall pattern on req_ready_i and without one, and it checks in each stalled cycle that the request held still.

// File: rtl/ifpf_pkg.sv
package ifpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef enum logic {
    FORM_BOUNDS = 1'b0,
    FORM_COUNT  = 1'b1
  } cmd_form_e;
endpackage

// File: rtl/ifpf_bound.sv
// Resolves a command into an exclusive end, an aligned first line and an empty flag.
module ifpf_bound
  import ifpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  cmd_form_e          form_i,
  input  logic [ADDR_W-1:0]  lo_i,
  input  logic [ADDR_W-1:0]  arg_i,
  output logic [ADDR_W-1:0]  end_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic               empty_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W:0]   sum_w;
  logic [ADDR_W-1:0] sat_w;

  always_comb begin
    sum_w = {1'b0, lo_i} + {1'b0, arg_i};
    sat_w = sum_w[ADDR_W] ? '1 : sum_w[ADDR_W-1:0];
  end

  generate
    if (LINE_BYTES > 1) begin : g_align
      assign base_o = lo_i & ~OFF_MASK;
    end else begin : g_noalign
      assign base_o = lo_i;
    end
  endgenerate

  assign end_o   = (form_i == FORM_COUNT) ? sat_w : arg_i;
  assign empty_o = (lo_i >= end_o);
endmodule

// File: rtl/ifpf_step.sv
// Next line boundary, clamped at the region end; carry-out treated as past the end.
module ifpf_step #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              reach_o
);
  logic [ADDR_W:0] raw_w;

  always_comb begin
    raw_w   = {1'b0, cur_i} + (ADDR_W+1)'(LINE_BYTES);
    reach_o = (raw_w >= {1'b0, end_i});
    nxt_o   = reach_o ? end_i : raw_w[ADDR_W-1:0];
  end
endmodule

// File: rtl/ifpf_seq.sv
module ifpf_seq
  import ifpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_fire_i,
  input  logic [ADDR_W-1:0] cmd_end_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic              cmd_empty_i,
  output logic              idle_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              done_valid_o,
  output logic [ADDR_W-1:0] done_addr_o
);
  localparam int unsigned CNT_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
  localparam int unsigned OFF_W   = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_LINES - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] cur_q, end_q, res_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] nxt_w;
  logic              reach_w;
  logic              req_fire_w;

  ifpf_step #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) step_i (
    .cur_i   (cur_q),
    .end_i   (end_q),
    .nxt_o   (nxt_w),
    .reach_o (reach_w)
  );

  assign idle_o       = (state_q == ST_IDLE);
  assign req_valid_o  = (state_q == ST_RUN);
  assign req_addr_o   = cur_q;
  assign done_valid_o = (state_q == ST_FIN);
  assign done_addr_o  = res_q;
  assign req_fire_w   = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_fire_i) begin
          end_q <= cmd_end_i;
          cnt_q <= '0;
          if (cmd_empty_i) begin
            res_q   <= cmd_end_i;
            state_q <= ST_FIN;
          end else begin
            cur_q   <= cmd_base_i;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (req_fire_w) begin
          if (reach_w || (cnt_q == CNT_LAST)) begin
            res_q   <= nxt_w;
            state_q <= ST_FIN;
          end else begin
            cur_q <= nxt_w;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker-side count of handshakes in the current invocation
  int unsigned issued_ctr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          issued_ctr <= 0;
    else if (cmd_fire_i)  issued_ctr <= 0;
    else if (req_fire_w)  issued_ctr <= issued_ctr + 1;
  end

  // R2
  line_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issued_ctr <= MAX_LINES);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !done_valid_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> !done_valid_o);

  // R10
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0));

  // R1
  below_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o < end_q));

  // R3
  result_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> (done_addr_o <= end_q));
endmodule

// File: rtl/ifetch_range_pf.sv
module ifetch_range_pf
  import ifpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_form_i,
  input  logic [ADDR_W-1:0] cmd_lo_i,
  input  logic [ADDR_W-1:0] cmd_arg_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              done_valid_o,
  output logic [ADDR_W-1:0] done_addr_o
);
  logic [ADDR_W-1:0] end_w, base_w;
  logic              empty_w, idle_w, fire_w;

  ifpf_bound #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) bound_i (
    .form_i  (cmd_form_e'(cmd_form_i)),
    .lo_i    (cmd_lo_i),
    .arg_i   (cmd_arg_i),
    .end_o   (end_w),
    .base_o  (base_w),
    .empty_o (empty_w)
  );

  assign cmd_ready_o = idle_w;
  assign fire_w      = cmd_valid_i && idle_w;

  ifpf_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LINES(MAX_LINES)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_fire_i   (fire_w),
    .cmd_end_i    (end_w),
    .cmd_base_i   (base_w),
    .cmd_empty_i  (empty_w),
    .idle_o       (idle_w),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .done_valid_o (done_valid_o),
    .done_addr_o  (done_addr_o)
  );

  // R7
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o || done_valid_o) |-> !cmd_ready_o);
endmodule

// File: tb/ifetch_range_pf_tb_top.sv
`timescale 1ns/1ps
module ifetch_range_pf_tb_top;
  localparam int MAXL = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_form_i = 1'b0;
  logic [31:0] cmd_lo_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b1;
  logic [31:0] req_addr_o;
  logic        done_valid_o;
  logic [31:0] done_addr_o;

  always #5 clk = ~clk;

  ifetch_range_pf #(.ADDR_W(32), .LINE_BYTES(64), .MAX_LINES(MAXL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_form_i(cmd_form_i),
    .cmd_lo_i(cmd_lo_i), .cmd_arg_i(cmd_arg_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .done_valid_o(done_valid_o), .done_addr_o(done_addr_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] exp_req_q[$];
  bit          exp_last_q[$];
  logic [31:0] exp_done_q[$];
  bit          exp_empty_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: predicts the result, queues it, then drives the command handshake
  task automatic submit(input bit form, input logic [31:0] lo, input logic [31:0] arg,
                        output logic [31:0] res);
    logic [32:0] sum, nxt;
    logic [31:0] e, cur;
    int n;
    bit stop;
    sum = {1'b0, lo} + {1'b0, arg};
    e = form ? (sum[32] ? 32'hFFFF_FFFF : sum[31:0]) : arg;
    if (lo >= e) begin
      res = e;
      exp_done_q.push_back(e);
      exp_empty_q.push_back(1'b1);
    end else begin
      cur = lo & ~32'h3F;
      n = 0;
      stop = 0;
      res = e;
      while (!stop) begin
        n++;
        nxt = {1'b0, cur} + 33'd64;
        stop = (nxt >= {1'b0, e}) || (n == MAXL);
        exp_req_q.push_back(cur);
        exp_last_q.push_back(stop);
        if (stop) res = (nxt >= {1'b0, e}) ? e : nxt[31:0];
        else cur = nxt[31:0];
      end
      exp_done_q.push_back(res);
      exp_empty_q.push_back(1'b0);
    end
    @(posedge clk); #1;
    cmd_valid_i = 1'b1;
    cmd_form_i  = form;
    cmd_lo_i    = lo;
    cmd_arg_i   = arg;
    while (!cmd_ready_o) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid_i = 1'b0;
    cmd_lo_i    = 32'hDEAD_BEEF;
    cmd_arg_i   = 32'h0BAD_F00D;
  endtask

  // ready pattern for the request port
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready_i = stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor: falling-edge sampling
  int cyc = 0;
  int last_cyc = -10;
  int acc_cyc = -10;
  bit prev_stall = 0;
  bit prev_done = 0;
  logic [31:0] prev_addr = '0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_ni) begin
        if (prev_stall) begin
          check("R6 valid held", {31'b0, req_valid_o}, 32'd1);
          check("R6 addr held", req_addr_o, prev_addr);
        end
        if (req_valid_o) check("R7 busy ready", {31'b0, cmd_ready_o}, 32'd0);
        if (req_valid_o && req_ready_i) begin
          check("R10 align", {26'b0, req_addr_o[5:0]}, 32'd0);
          if (exp_req_q.size() == 0) check("R2 extra request", req_addr_o, 32'hFFFF_FFFF);
          else begin
            check("R1 line addr", req_addr_o, exp_req_q.pop_front());
            if (exp_last_q.pop_front()) last_cyc = cyc;
          end
        end
        if (cmd_valid_i && cmd_ready_o) acc_cyc = cyc;
        if (done_valid_o) begin
          if (prev_done) check("R8 single pulse", 32'd1, 32'd0);
          if (exp_done_q.size() == 0) check("R3 extra done", done_addr_o, 32'hFFFF_FFFF);
          else begin
            check("R3 done addr", done_addr_o, exp_done_q.pop_front());
            if (exp_empty_q.pop_front()) check("R4 done timing", cyc, acc_cyc + 1);
            else check("R8 done timing", cyc, last_cyc + 1);
          end
        end
        prev_stall = req_valid_o && !req_ready_i;
        prev_addr  = req_addr_o;
        prev_done  = done_valid_o;
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((exp_done_q.size() != 0 || exp_req_q.size() != 0) && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    check("drain all results", exp_done_q.size() + exp_req_q.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r, lo;
    int guard;
    #23;
    // R11 reset state
    check("R11 cmd_ready", {31'b0, cmd_ready_o}, 32'd1);
    check("R11 req_valid", {31'b0, req_valid_o}, 32'd0);
    check("R11 done_valid", {31'b0, done_valid_o}, 32'd0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {30'b0, cmd_ready_o, req_valid_o | done_valid_o}, 32'd2);

    // R1 R3: aligned four-line range
    submit(0, 32'h0000_1000, 32'h0000_1100, r);
    check("R3 model 0x1100", r, 32'h0000_1100);
    // R1 R3: unaligned lower and clamped result
    submit(0, 32'h0000_2010, 32'h0000_2050, r);
    // R4: equal and inverted bounds
    submit(0, 32'h0000_5000, 32'h0000_5000, r);
    submit(0, 32'h0000_6100, 32'h0000_6000, r);
    // R5: count form
    submit(1, 32'h0000_4020, 32'h0000_0080, r);
    // R5 R4: zero count
    submit(1, 32'h0000_4400, 32'h0000_0000, r);
    drain();

    // R2 R3: long region covered by resuming
    lo = 32'h0000_3000;
    guard = 0;
    do begin
      submit(0, lo, 32'h0000_3400, r);
      lo = r;
      guard++;
    end while (lo != 32'h0000_3400 && guard < 10);
    check("R3 resume count", guard, 4);
    drain();

    // R9: top of address space, bounds form and saturated count form
    submit(0, 32'hFFFF_FF80, 32'hFFFF_FFF0, r);
    submit(1, 32'hFFFF_FFC0, 32'h0000_0100, r);
    check("R9 saturated result", r, 32'hFFFF_FFFF);
    drain();

    // R6 R7: stalls on the request port, back-to-back commands
    stall_en = 1;
    submit(0, 32'h0000_7000, 32'h0000_7100, r);
    submit(0, 32'h0000_8030, 32'h0000_8200, r);
    submit(1, 32'h0000_9000, 32'h0000_0041, r);
    submit(0, 32'h0000_A000, 32'h0000_9000, r);
    submit(0, 32'h0000_B000, 32'h0000_B040, r);
    drain();
    stall_en = 0;
    repeat (5) @(posedge clk);
    summary();
  end
endmodule